// File: doc/BRIEF.md
# Receive byte-to-word packet packer

This block sits behind an Ethernet receive MAC that has no buffer of its own. The MAC delivers one byte per cycle with a valid strobe. It then marks the end of the frame with a one-cycle good or bad strobe. The block tags each byte with a ninth end-of-packet bit and packs four such 9-bit lanes into a 36-bit word. It stores those words in a single-clock packet FIFO. When a frame ends partway through a word, the unused lanes are padded. After the last data word of every stored frame, one status word is appended that says whether the frame is to be kept or discarded.

Space is managed per packet. A new frame is only admitted while there is room for a maximum-size frame plus its status word. A frame that is refused is discarded whole. A frame that outgrows the remaining room is truncated, but it is still closed with an EOP and a bad status. On the read side, a consumer pops words with a read enable and watches a packet-available flag. That flag follows an internal count of complete packets and dips for one cycle after each EOP word is presented. Two counters record packets lost to lack of space and packets that ended with a bad-frame strobe.

Top module: `rxp_rx_packer`

## Requirements
- R1: After reset, empty_o is 1, and pkt_avail_o, rd_valid_o, almost_full_o, drop_cnt_o and bad_cnt_o are all 0.
- R2: Lane k (k = 0..3) of a stored word occupies bits 9k+8..9k. The byte is in bits 9k+7..9k and its EOP flag is in bit 9k+8, so the flags sit at bits 35, 26, 17 and 8. The first byte of each word goes in lane 0 and later bytes fill higher lanes in arrival order.
- R3: Only the last stored byte of a packet has its EOP flag set. Lanes after it in the final word are pad lanes, and all nine bits of each pad lane are zero.
- R4: Every stored packet is followed directly in the FIFO by one status word. Bit 0 of that word is 1 if the packet ended with rx_bad_i or was truncated, and 0 otherwise. Bits 35..1 are zero.
- R5: With MW = ceil(MAX_PKT_BYTES/4), a packet is admitted only if at least MW+1 words are free when its first byte arrives, not counting a status word being written in that same cycle. almost_full_o is 1 exactly when fewer than MW+1 words are free. A refused packet stores nothing and adds 1 to drop_cnt_o.
- R6: Within a packet, a full word that is not the last is written only if at least 3 words are free. Otherwise the rest of the packet is discarded. The held word is then stored with EOP on lane 3 and a bad status, and drop_cnt_o adds 1. The FIFO is never written while full.
- R7: bad_cnt_o adds 1 for every packet with at least one byte that ends with rx_bad_i, whether it was stored, truncated or refused.
- R8: rd_en_i while the FIFO is not empty pops the head word. That word appears on rd_data_o with rd_valid_o = 1 in the next cycle. rd_en_i while empty_o is 1 has no effect.
- R9: Outside the dip of R10, pkt_avail_o is 1 exactly when the complete-packet count is nonzero. The count rises when a status word is written and falls when a status word is popped.
- R10: In the cycle after rd_valid_o is 1 with any EOP flag set in rd_data_o, pkt_avail_o is 0. In the cycle after that, it follows R9 again.
- R11: An end strobe with no bytes received since the previous end stores nothing and changes no counter. The first byte of a new packet may arrive in the cycle right after an end strobe. A byte presented with valid in the same cycle as an end strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | rx_data_i holds a byte of the current frame |
| rx_good_i | input | 1 | One-cycle strobe: frame ended with a good check |
| rx_bad_i | input | 1 | One-cycle strobe: frame ended with a bad check |
| rd_en_i | input | 1 | Pop the head word |
| rd_data_o | output | 36 | Word popped in the previous cycle |
| rd_valid_o | output | 1 | rd_data_o was updated by a pop in the previous cycle |
| empty_o | output | 1 | FIFO holds no words |
| pkt_avail_o | output | 1 | At least one complete packet is stored |
| almost_full_o | output | 1 | Fewer than MW+1 words are free |
| drop_cnt_o | output | CNT_W | Packets refused or truncated for lack of space |
| bad_cnt_o | output | CNT_W | Packets that ended with the bad strobe |

## Verification
Frames of every length from 1 to 16 bytes are sent with both end strobes into a FIFO that is otherwise empty. This covers all four final-lane positions, padding of 0 to 3 lanes, and both status values. Back-to-back frames that start in the status-write cycle show whether the status reservation collides with a new frame's first byte. Filling the FIFO until a frame is refused separates whole-packet refusal from truncation. A long frame started with exactly MW+1 free words forces truncation at a known byte. Reading two stored packets word by word distinguishes the one-cycle availability dip from the count-driven level.

// File: rtl/rxp_pkg.sv
`timescale 1ns/1ps
package rxp_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STORE,
    ST_TRUNC,
    ST_REFUSE
  } pk_state_e;

  function automatic logic word_has_eop(word_t w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANES; i++) r = r | w[i*LANE_W + 8];
    return r;
  endfunction

  function automatic word_t put_byte(word_t w, logic [2:0] lane, logic [7:0] b);
    word_t r;
    r = w;
    for (int i = 0; i < LANES; i++)
      if (int'(lane) == i) r[i*LANE_W +: 8] = b;
    return r;
  endfunction

  function automatic word_t set_eop(word_t w, logic [2:0] lane);
    word_t r;
    r = w;
    for (int i = 0; i < LANES; i++)
      if (int'(lane) == i) r[i*LANE_W + 8] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rxp_word_fifo.sv
`timescale 1ns/1ps
module rxp_word_fifo import rxp_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  word_t         wr_data_i,
  input  logic          rd_en_i,
  output word_t         rd_data_o,
  output logic          rd_valid_o,
  output logic          pop_o,
  output logic [AW:0]   count_o
);
  // DEPTH must be a power of two: pointers wrap naturally
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   cnt_q;
  word_t         mem_q [DEPTH];
  word_t         rd_data_q;
  logic          rd_valid_q;

  assign pop_o = rd_en_i & (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      cnt_q      <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_o) begin
        rd_ptr_q  <= rd_ptr_q + 1'b1;
        rd_data_q <= mem_q[rd_ptr_q];
      end
      rd_valid_q <= pop_o;
      unique case ({wr_en_i, pop_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign count_o    = cnt_q;
endmodule

// File: rtl/rxp_packer.sv
`timescale 1ns/1ps
module rxp_packer import rxp_pkg::*; #(
  parameter int MAX_PKT_BYTES = 1518,
  parameter int FREE_W        = 10,
  parameter int CNT_W         = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_good_i,
  input  logic              rx_bad_i,
  input  logic [FREE_W-1:0] free_words_i,
  output logic              wr_en_o,
  output word_t             wr_data_o,
  output logic              stat_wr_o,
  output logic [CNT_W-1:0]  drop_cnt_o,
  output logic [CNT_W-1:0]  bad_cnt_o
);
  localparam int MAX_WORDS  = (MAX_PKT_BYTES + LANES - 1) / LANES;
  localparam int START_NEED = MAX_WORDS + 1;
  // room for this word, the closing EOP word and the status word
  localparam int MID_NEED   = 3;

  pk_state_e  st_q, st_d;
  word_t      word_q, word_d;
  logic [2:0] lanes_q, lanes_d;
  logic       stat_pend_q, stat_pend_d;
  logic       stat_bad_q, stat_bad_d;
  logic [CNT_W-1:0] drop_q, bad_q;
  logic       drop_inc, bad_inc;
  logic       end_w, start_ok, mid_ok;

  assign end_w    = rx_good_i | rx_bad_i;
  assign start_ok = int'(free_words_i) >= START_NEED + int'(stat_pend_q);
  assign mid_ok   = int'(free_words_i) >= MID_NEED;

  always_comb begin
    st_d        = st_q;
    word_d      = word_q;
    lanes_d     = lanes_q;
    stat_pend_d = 1'b0;
    stat_bad_d  = stat_bad_q;
    wr_en_o     = 1'b0;
    wr_data_o   = '0;
    drop_inc    = 1'b0;
    bad_inc     = 1'b0;
    if (stat_pend_q) begin
      wr_en_o   = 1'b1;
      wr_data_o = {{(WORD_W-1){1'b0}}, stat_bad_q};
    end
    unique case (st_q)
      ST_IDLE: begin
        if (!end_w && rx_valid_i) begin
          if (start_ok) begin
            st_d    = ST_STORE;
            word_d  = put_byte('0, 3'd0, rx_data_i);
            lanes_d = 3'd1;
          end else begin
            st_d = ST_REFUSE;
          end
        end
      end
      ST_STORE: begin
        if (end_w) begin
          wr_en_o     = 1'b1;
          wr_data_o   = set_eop(word_q, lanes_q - 3'd1);
          stat_pend_d = 1'b1;
          stat_bad_d  = rx_bad_i;
          bad_inc     = rx_bad_i;
          st_d        = ST_IDLE;
          word_d      = '0;
          lanes_d     = 3'd0;
        end else if (rx_valid_i) begin
          if (lanes_q == 3'd4) begin
            if (mid_ok) begin
              wr_en_o   = 1'b1;
              wr_data_o = word_q;
              word_d    = put_byte('0, 3'd0, rx_data_i);
              lanes_d   = 3'd1;
            end else begin
              st_d = ST_TRUNC;
            end
          end else begin
            word_d  = put_byte(word_q, lanes_q, rx_data_i);
            lanes_d = lanes_q + 3'd1;
          end
        end
      end
      ST_TRUNC: begin
        if (end_w) begin
          wr_en_o     = 1'b1;
          wr_data_o   = set_eop(word_q, 3'd3);
          stat_pend_d = 1'b1;
          stat_bad_d  = 1'b1;
          drop_inc    = 1'b1;
          bad_inc     = rx_bad_i;
          st_d        = ST_IDLE;
          word_d      = '0;
          lanes_d     = 3'd0;
        end
      end
      ST_REFUSE: begin
        if (end_w) begin
          drop_inc = 1'b1;
          bad_inc  = rx_bad_i;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      word_q      <= '0;
      lanes_q     <= 3'd0;
      stat_pend_q <= 1'b0;
      stat_bad_q  <= 1'b0;
      drop_q      <= '0;
      bad_q       <= '0;
    end else begin
      st_q        <= st_d;
      word_q      <= word_d;
      lanes_q     <= lanes_d;
      stat_pend_q <= stat_pend_d;
      stat_bad_q  <= stat_bad_d;
      drop_q      <= drop_q + {{(CNT_W-1){1'b0}}, drop_inc};
      bad_q       <= bad_q + {{(CNT_W-1){1'b0}}, bad_inc};
    end
  end

  assign stat_wr_o  = stat_pend_q;
  assign drop_cnt_o = drop_q;
  assign bad_cnt_o  = bad_q;
endmodule

// File: rtl/rxp_avail.sv
`timescale 1ns/1ps
module rxp_avail import rxp_pkg::*; #(
  parameter int PCNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_wr_i,
  input  logic              pop_i,
  input  logic              rd_valid_i,
  input  word_t             rd_data_i,
  output logic [PCNT_W-1:0] pkt_cnt_o,
  output logic              pkt_avail_o
);
  logic              eop_vis, stat_pop;
  logic              nxt_stat_q, hold_q;
  logic [PCNT_W-1:0] cnt_q;

  // the word popped after an EOP word is always that packet's status
  assign eop_vis  = rd_valid_i & word_has_eop(rd_data_i);
  assign stat_pop = pop_i & (nxt_stat_q | eop_vis);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_stat_q <= 1'b0;
      hold_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      nxt_stat_q <= pop_i ? 1'b0 : (nxt_stat_q | eop_vis);
      hold_q     <= eop_vis;
      unique case ({stat_wr_i, stat_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pkt_cnt_o   = cnt_q;
  assign pkt_avail_o = (cnt_q != '0) & ~hold_q;
endmodule

// File: rtl/rxp_rx_packer.sv
`timescale 1ns/1ps
module rxp_rx_packer import rxp_pkg::*; #(
  parameter int MAX_PKT_BYTES = 1518,
  parameter int DEPTH_WORDS   = 512,
  parameter int CNT_W         = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  input  logic             rx_good_i,
  input  logic             rx_bad_i,
  input  logic             rd_en_i,
  output logic [35:0]      rd_data_o,
  output logic             rd_valid_o,
  output logic             empty_o,
  output logic             pkt_avail_o,
  output logic             almost_full_o,
  output logic [CNT_W-1:0] drop_cnt_o,
  output logic [CNT_W-1:0] bad_cnt_o
);
  localparam int AW         = $clog2(DEPTH_WORDS);
  localparam int FW         = AW + 1;
  localparam int MAX_WORDS  = (MAX_PKT_BYTES + LANES - 1) / LANES;
  localparam int START_NEED = MAX_WORDS + 1;

  word_t         wr_data;
  logic          wr_en, stat_wr, pop;
  logic [FW-1:0] fifo_cnt, free_words, pkt_cnt;
  word_t         rd_word;

  assign free_words = FW'(DEPTH_WORDS) - fifo_cnt;

  rxp_packer #(
    .MAX_PKT_BYTES(MAX_PKT_BYTES),
    .FREE_W       (FW),
    .CNT_W        (CNT_W)
  ) u_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_data_i   (rx_data_i),
    .rx_valid_i  (rx_valid_i),
    .rx_good_i   (rx_good_i),
    .rx_bad_i    (rx_bad_i),
    .free_words_i(free_words),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .stat_wr_o   (stat_wr),
    .drop_cnt_o  (drop_cnt_o),
    .bad_cnt_o   (bad_cnt_o)
  );

  rxp_word_fifo #(
    .DEPTH(DEPTH_WORDS)
  ) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_word),
    .rd_valid_o(rd_valid_o),
    .pop_o     (pop),
    .count_o   (fifo_cnt)
  );

  rxp_avail #(
    .PCNT_W(FW)
  ) u_avail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_wr_i  (stat_wr),
    .pop_i      (pop),
    .rd_valid_i (rd_valid_o),
    .rd_data_i  (rd_word),
    .pkt_cnt_o  (pkt_cnt),
    .pkt_avail_o(pkt_avail_o)
  );

  assign rd_data_o     = rd_word;
  assign empty_o       = (fifo_cnt == '0);
  assign almost_full_o = int'(free_words) < START_NEED;
endmodule

// File: rtl/rxp_checker.sv
`timescale 1ns/1ps
module rxp_checker import rxp_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int FW    = 5,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en,
  input word_t            wr_data,
  input logic [FW-1:0]    fifo_cnt,
  input logic [FW-1:0]    pkt_cnt,
  input logic             rd_en_i,
  input logic             empty_o,
  input logic             rd_valid_o,
  input logic [35:0]      rd_data_o,
  input logic             pkt_avail_o,
  input logic [CNT_W-1:0] drop_cnt_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (int'(fifo_cnt) < DEPTH)); // R6

  AST_STATUS_FOLLOWS_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && word_has_eop(wr_data)) |=> (wr_en && (wr_data[WORD_W-1:1] == '0))); // R4

  AST_POP_SHOWS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_o) |=> rd_valid_o); // R8

  AST_EMPTY_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> !rd_valid_o); // R8

  AST_AVAIL_DIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && word_has_eop(rd_data_o)) |=> !pkt_avail_o); // R10

  AST_AVAIL_NEEDS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_avail_o |-> (pkt_cnt != '0)); // R9

  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + 1'b1)); // R5
endmodule

bind rxp_rx_packer rxp_checker #(
  .DEPTH(DEPTH_WORDS),
  .FW   (FW),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .fifo_cnt   (fifo_cnt),
  .pkt_cnt    (pkt_cnt),
  .rd_en_i    (rd_en_i),
  .empty_o    (empty_o),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .pkt_avail_o(pkt_avail_o),
  .drop_cnt_o (drop_cnt_o)
);

// File: tb/sim_rxp_rx_packer.sv
`timescale 1ns/1ps
module sim_rxp_rx_packer;
  localparam int MAXB  = 16;
  localparam int DEPTH = 16;
  localparam int CNT_W = 8;
  localparam int MAXW  = (MAXB + 3) / 4;
  localparam int NEED  = MAXW + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       rx_data = '0;
  logic             rx_valid = 1'b0, rx_good = 1'b0, rx_bad = 1'b0, rd_en = 1'b0;
  logic [35:0]      rd_data;
  logic             rd_valid, empty, avail, afull;
  logic [CNT_W-1:0] drop_cnt, bad_cnt;

  int n_chk = 0, n_fail = 0;
  int occ = 0, exp_drop = 0, exp_bad = 0;
  bit done = 1'b0;
  logic [35:0] exp_q[$];

  always #10 clk = ~clk;

  rxp_rx_packer #(.MAX_PKT_BYTES(MAXB), .DEPTH_WORDS(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_good_i(rx_good), .rx_bad_i(rx_bad), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .empty_o(empty), .pkt_avail_o(avail), .almost_full_o(afull),
    .drop_cnt_o(drop_cnt), .bad_cnt_o(bad_cnt));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(int seed, int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  // expected FIFO contents from the stated rules
  task automatic model_pkt(int n, bit bad, int seed);
    int f, nw, keep, last;
    bit trunc;
    logic [35:0] w;
    if (n == 0) return;
    if (bad) exp_bad++;
    f = DEPTH - occ;
    if (f < NEED) begin exp_drop++; return; end
    nw = (n + 3) / 4; keep = nw; trunc = 1'b0;
    for (int k = 0; k < nw - 1; k++) begin
      if (f >= 3) f--;
      else begin trunc = 1'b1; keep = k + 1; break; end
    end
    last = trunc ? keep * 4 - 1 : n - 1;
    for (int k = 0; k < keep; k++) begin
      w = '0;
      for (int l = 0; l < 4; l++) begin
        int i;
        i = k * 4 + l;
        if (i <= last) begin
          w[l*9 +: 8] = bval(seed, i);
          w[l*9 + 8]  = (i == last);
        end
      end
      exp_q.push_back(w);
    end
    exp_q.push_back({35'd0, bad | trunc});
    occ += keep + 1;
    if (trunc) exp_drop++;
  endtask

  task automatic send_pkt(int n, bit bad, int seed, int gap);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = bval(seed, i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_good = !bad; rx_bad = bad;
    @(negedge clk);
    rx_good = 1'b0; rx_bad = 1'b0;
    repeat (gap) @(negedge clk);
    model_pkt(n, bad, seed);
  endtask

  task automatic drain(string tag);
    logic [35:0] e;
    while (!empty) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check({tag, " R8 valid"}, 64'(rd_valid), 64'd1);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 36'hF_FFFF_FFFF;
      check({tag, " R2/R3/R4 word"}, 64'(rd_data), 64'(e));
      occ--;
    end
    check({tag, " R4 leftover"}, 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    check({tag, " R9 avail after drain"}, 64'(avail), 64'd0);
  endtask

  task automatic check_counts(string tag);
    check({tag, " R5/R6 drop"}, 64'(drop_cnt), 64'(exp_drop));
    check({tag, " R7 bad"}, 64'(bad_cnt), 64'(exp_bad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 64'(empty), 64'd1);
    check("R1 avail", 64'(avail), 64'd0);
    check("R1 valid", 64'(rd_valid), 64'd0);
    check("R1 afull", 64'(afull), 64'd0);
    check_counts("R1");

    // R8 read while empty
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R8 empty read valid", 64'(rd_valid), 64'd0);
    check("R8 empty stays", 64'(empty), 64'd1);

    // R11 empty strobe
    send_pkt(0, 1'b1, 0, 2);
    check("R11 empty strobe stores nothing", 64'(empty), 64'd1);
    check_counts("R11");

    // sweep of lengths and both strobes
    for (int n = 1; n <= MAXB; n++) begin
      for (int b = 0; b < 2; b++) begin
        send_pkt(n, b[0], n * 2 + b, 1);
        check("R9 avail after store", 64'(avail), 64'd1);
        drain("sweep");
      end
    end
    check_counts("sweep");

    // R11 back-to-back packets, next first byte in status cycle
    send_pkt(5, 1'b0, 40, 0);
    send_pkt(3, 1'b1, 41, 0);
    send_pkt(9, 1'b0, 42, 2);
    drain("R11 back-to-back");
    check_counts("R11 b2b");

    // R10 dip with two packets stored
    send_pkt(4, 1'b0, 50, 1);
    send_pkt(6, 1'b0, 51, 2);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R2/R3 first word", 64'(rd_data), 64'(exp_q.pop_front())); occ--;
    check("R10 avail before dip", 64'(avail), 64'd1);
    @(negedge clk);
    check("R10 avail dip", 64'(avail), 64'd0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R4 status word", 64'(rd_data), 64'(exp_q.pop_front())); occ--;
    check("R10/R9 avail restored", 64'(avail), 64'd1);
    drain("R10");

    // R5 refusal when full
    send_pkt(16, 1'b0, 60, 1);
    send_pkt(16, 1'b1, 61, 1);
    check("R5 afull low with room", 64'(afull), 64'd0);
    send_pkt(16, 1'b0, 62, 1);
    check("R5 afull high", 64'(afull), 64'd1);
    send_pkt(8, 1'b1, 63, 1);
    check_counts("R5 refuse");
    drain("R5");

    // R6 truncation with exactly NEED words free
    send_pkt(16, 1'b0, 70, 1);
    send_pkt(12, 1'b0, 71, 1);
    send_pkt(4, 1'b0, 72, 1);
    check("R5 afull at threshold", 64'(afull), 64'd0);
    send_pkt(24, 1'b0, 73, 1);
    check("R6 fifo full afterwards", 64'(afull), 64'd1);
    check_counts("R6 trunc");
    drain("R6");
    check("R6 empty at end", 64'(empty), 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule